// File: doc/BRIEF.md
# CPU Sleep and Stop Sequencer

This block sits on the chipset side of a CPU and owns two active-low control lines towards it: a reset line and a stop line. Both are meant to drive open-drain pads, so the block only decides when each line is pulled low. It watches power-good, suspend status, a sleep-depth select, stop-grant, the CPU stop signal, the S2 sleep signal and a wake event. From these it walks the CPU into and out of the C3 idle state and the S1 to S5 sleep states in the right order.

Each sleep state has its own way out. S1 waits for the CPU stop signal to fall and then counts a programmed delay. S2 waits for the S2 sleep signal to fall. S3 to S5 leave only through a power cycle. C3 counts a programmed delay after a wake event. A small write port loads the two delay registers and a control register. A control bit routes the processor-hot input to an SCI pulse or an SMI pulse. A sticky status bit records each hot event until software clears it.

Top module: `cpu_slp_seq`

## Requirements
- R1: While power-good is low at a rising clock edge, both cpu_rst_n and cpu_stop_n are low after that edge, whatever the prior state. This is also the state after reset.
- R2: When power-good is high at an edge in the off state, both outputs are high after that edge.
- R3: In the running state, sus_stat high at an edge pulls cpu_stop_n low after that edge while cpu_rst_n stays high. slp_sel picks the sleep state: 0 is S1, 1 is S2, 2 or 3 is S3 to S5.
- R4: In the running state, stp_grant high at an edge with sus_stat low enters C3 and pulls cpu_stop_n low. When both are high, sus_stat wins and the sleep state is entered.
- R5: In the running state with neither sus_stat nor stp_grant high, cpu_stop_n stays high, whatever the other inputs do.
- R6: In S1, a fall of cpu_stp between two consecutive edges starts the S1 delay d. cpu_stop_n goes high after the (d+1)-th edge following the edge that saw the fall.
- R7: In S2, a fall of slp_s2 between two consecutive edges releases cpu_stop_n after the edge that saw the fall.
- R8: In S3 to S5, cpu_stop_n stays low until power-good goes low and then high again. Both outputs are released together.
- R9: In C3, cpu_stop_n stays low until wake_evt is seen at an edge. It goes high after the (d+1)-th following edge, where d is the C3 delay.
- R10: Writing with wr_en high loads a register: address 0 is the S1 delay and address 1 is the C3 delay. Both are DLY_W bits wide and reset to DLY_INIT. A delay of 0 releases after the edge that follows the event edge, and the largest value 255 releases after 256 edges.
- R11: proc_hot passes through two synchronizer flops. Its rising edge gives one one-cycle pulse two edges after it is first sampled. The pulse goes to sci_req when the mode bit (address 2, data bit 0) is 0 and to smi_req when it is 1. The two outputs are never high together.
- R12: hot_status is set by each hot pulse and cleared by a write to address 2 with data bit 1 set. A pulse in the same cycle as a clear wins. A write to address 2 with bit 1 clear leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good, high when supplies are valid |
| sus_stat | input | 1 | Suspend status asserted (high) |
| slp_sel | input | 2 | Sleep depth: 0 S1, 1 S2, 2/3 S3 to S5 |
| stp_grant | input | 1 | Stop-grant received (high) |
| cpu_stp | input | 1 | CPU stop signal, high while asserted |
| slp_s2 | input | 1 | S2 sleep signal, high while asserted |
| wake_evt | input | 1 | Wake event for C3 |
| proc_hot | input | 1 | Processor-hot, high while hot, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DLY_W | Register write data |
| cpu_rst_n | output | 1 | CPU reset, active low |
| cpu_stop_n | output | 1 | CPU stop, active low |
| sci_req | output | 1 | One-cycle SCI request |
| smi_req | output | 1 | One-cycle SMI request |
| hot_status | output | 1 | Sticky processor-hot status |

## Verification
The bench builds the block with DLY_W of 8 and DLY_INIT of 2. A short reset value lets the first C3 exit run on the untouched register, which checks the reset contents. Writes of 0, 3 and 255 then cover the shortest release, an ordinary one and the full 8-bit count. With 8-bit delays the longest release is 256 cycles, so the bench can cover every sleep path, the power-good override in the middle of a count, and both hot-event routings within a short run.

// File: rtl/cpu_slp_seq.sv
module cpu_slp_seq #(
  parameter int DLY_W = 8,
  parameter logic [DLY_W-1:0] DLY_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             sus_stat,
  input  logic [1:0]       slp_sel,
  input  logic             stp_grant,
  input  logic             cpu_stp,
  input  logic             slp_s2,
  input  logic             wake_evt,
  input  logic             proc_hot,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DLY_W-1:0] wr_data,
  output logic             cpu_rst_n,
  output logic             cpu_stop_n,
  output logic             sci_req,
  output logic             smi_req,
  output logic             hot_status
);

  typedef enum logic [2:0] {
    ST_OFF, ST_RUN, ST_SL1, ST_SL2, ST_DEEP, ST_C3, ST_TMR
  } st_t;

  st_t state, state_nx;
  logic [DLY_W-1:0] s1_dly, c3_dly, cnt, cnt_nx;
  logic hot_mode;
  logic cpu_stp_q, slp_s2_q;
  logic [2:0] hot_sync;
  logic hot_pulse, clr_hot;

  wire stp_fall = cpu_stp_q & ~cpu_stp;
  wire s2_fall  = slp_s2_q & ~slp_s2;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    if (!pwr_good) begin
      state_nx = ST_OFF;
    end else begin
      case (state)
        ST_OFF:  state_nx = ST_RUN;
        ST_RUN:
          if (sus_stat)
            state_nx = (slp_sel == 2'd0) ? ST_SL1 :
                       (slp_sel == 2'd1) ? ST_SL2 : ST_DEEP;
          else if (stp_grant)
            state_nx = ST_C3;
        ST_SL1:
          if (stp_fall) begin
            state_nx = ST_TMR;
            cnt_nx   = s1_dly;
          end
        ST_SL2:  if (s2_fall) state_nx = ST_RUN;
        ST_C3:
          if (wake_evt) begin
            state_nx = ST_TMR;
            cnt_nx   = c3_dly;
          end
        ST_TMR:
          if (cnt == '0) state_nx = ST_RUN;
          else           cnt_nx   = cnt - 1'b1;
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      cnt       <= '0;
      cpu_stp_q <= 1'b0;
      slp_s2_q  <= 1'b0;
    end else begin
      state     <= state_nx;
      cnt       <= cnt_nx;
      cpu_stp_q <= cpu_stp;
      slp_s2_q  <= slp_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_dly   <= DLY_INIT;
      c3_dly   <= DLY_INIT;
      hot_mode <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: s1_dly <= wr_data;
        2'd1: c3_dly <= wr_data;
        2'd2: hot_mode <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign clr_hot   = wr_en && wr_addr == 2'd2 && wr_data[1];
  assign hot_pulse = hot_sync[1] & ~hot_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_sync   <= '0;
      hot_status <= 1'b0;
    end else begin
      hot_sync <= {hot_sync[1:0], proc_hot};
      if (hot_pulse)    hot_status <= 1'b1;
      else if (clr_hot) hot_status <= 1'b0;
    end
  end

  assign cpu_rst_n  = (state != ST_OFF);
  assign cpu_stop_n = (state == ST_RUN);
  assign sci_req    = hot_pulse & ~hot_mode;
  assign smi_req    = hot_pulse & hot_mode;

  p_pg_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!cpu_rst_n && !cpu_stop_n));

  p_off_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rst_n && pwr_good) |=> (cpu_rst_n && cpu_stop_n));

  p_no_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stop_n && pwr_good && !sus_stat && !stp_grant) |=> cpu_stop_n);

  p_s2_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SL2 && pwr_good && slp_s2_q && !slp_s2) |=> cpu_stop_n);

  p_deep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEEP && pwr_good) |=> !cpu_stop_n);

  p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sci_req, smi_req}));

  p_pulse_short_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_req || smi_req) |=> !(sci_req || smi_req));

  p_status_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_req || smi_req) |=> hot_status);

endmodule

// File: tb/cpu_slp_seq_bench.sv
module cpu_slp_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 0, sus_stat = 0, stp_grant = 0, cpu_stp = 0, slp_s2 = 0;
  logic wake_evt = 0, proc_hot = 0, wr_en = 0;
  logic [1:0] slp_sel = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic cpu_rst_n, cpu_stop_n, sci_req, smi_req, hot_status;

  int total = 0, bad = 0;
  bit done = 0, cmp_on = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  cpu_slp_seq #(.DLY_W(8), .DLY_INIT(8'd2)) u_cpu_slp_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sus_stat(sus_stat),
    .slp_sel(slp_sel), .stp_grant(stp_grant), .cpu_stp(cpu_stp), .slp_s2(slp_s2),
    .wake_evt(wake_evt), .proc_hot(proc_hot), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_rst_n(cpu_rst_n), .cpu_stop_n(cpu_stop_n),
    .sci_req(sci_req), .smi_req(smi_req), .hot_status(hot_status));

  // reference model: 0 off, 1 run, 2 S1, 3 S2, 4 deep, 5 C3, 6 counting
  int m_st = 0, m_cnt = 0, m_s1 = 2, m_c3 = 2, m_mode = 0, m_stat = 0;
  int h1 = 0, h2 = 0, h3 = 0, p_stp = 0, p_s2 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_s1 = 2; m_c3 = 2; m_mode = 0; m_stat = 0;
      h1 = 0; h2 = 0; h3 = 0; p_stp = 0; p_s2 = 0;
    end else begin
      if (h2 == 1 && h3 == 0) m_stat = 1;
      else if (wr_en && wr_addr == 2 && wr_data[1]) m_stat = 0;
      h3 = h2; h2 = h1; h1 = proc_hot;
      if (!pwr_good) m_st = 0;
      else if (m_st == 0) m_st = 1;
      else if (m_st == 1) begin
        if (sus_stat) m_st = (slp_sel == 0) ? 2 : (slp_sel == 1) ? 3 : 4;
        else if (stp_grant) m_st = 5;
      end else if (m_st == 2) begin
        if (p_stp == 1 && !cpu_stp) begin m_st = 6; m_cnt = m_s1; end
      end else if (m_st == 3) begin
        if (p_s2 == 1 && !slp_s2) m_st = 1;
      end else if (m_st == 5) begin
        if (wake_evt) begin m_st = 6; m_cnt = m_c3; end
      end else if (m_st == 6) begin
        if (m_cnt == 0) m_st = 1; else m_cnt = m_cnt - 1;
      end
      p_stp = cpu_stp; p_s2 = slp_s2;
      if (wr_en) begin
        if (wr_addr == 0) m_s1 = wr_data;
        else if (wr_addr == 1) m_c3 = wr_data;
        else if (wr_addr == 2) m_mode = wr_data[0];
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done) begin
    chk("R1", "model cpu_rst_n", cpu_rst_n, m_st != 0);
    chk(cur_tag, "model cpu_stop_n", cpu_stop_n, m_st == 1);
    chk("R11", "model sci_req", sci_req, (h2 == 1 && h3 == 0 && m_mode == 0));
    chk("R11", "model smi_req", smi_req, (h2 == 1 && h3 == 0 && m_mode == 1));
    chk("R12", "model hot_status", hot_status, m_stat);
  end

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic release_after(int d, string tag);
    chk(tag, "stop held at event edge", cpu_stop_n, 0);
    repeat (d) step();
    chk(tag, "stop held before last edge", cpu_stop_n, 0);
    step();
    chk(tag, "stop released", cpu_stop_n, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk("R1", "reset cpu_rst_n", cpu_rst_n, 0);
    chk("R1", "reset cpu_stop_n", cpu_stop_n, 0);
    chk("R12", "reset hot_status", hot_status, 0);
    rst_n = 1; cmp_on = 1;
    step();
    chk("R1", "off without power-good", cpu_rst_n, 0);
    cur_tag = "R2"; pwr_good = 1; step();
    chk("R2", "reset released", cpu_rst_n, 1);
    chk("R2", "stop released", cpu_stop_n, 1);

    cur_tag = "R9"; stp_grant = 1; step(); stp_grant = 0;
    chk("R4", "C3 entry stop", cpu_stop_n, 0);
    chk("R4", "C3 entry reset high", cpu_rst_n, 1);
    repeat (3) step();
    chk("R9", "C3 waits for wake", cpu_stop_n, 0);
    wake_evt = 1; step(); wake_evt = 0;
    release_after(2, "R9");

    cur_tag = "R6"; wr(2'd0, 8'd3);
    sus_stat = 1; slp_sel = 0; step(); sus_stat = 0;
    chk("R3", "S1 entry stop", cpu_stop_n, 0);
    cpu_stp = 1; repeat (4) step();
    chk("R6", "S1 held while cpu_stp high", cpu_stop_n, 0);
    cpu_stp = 0; step();
    release_after(3, "R6");

    cur_tag = "R7"; sus_stat = 1; slp_sel = 1; step(); sus_stat = 0;
    chk("R3", "S2 entry stop", cpu_stop_n, 0);
    slp_s2 = 1; repeat (3) step();
    chk("R7", "S2 held", cpu_stop_n, 0);
    slp_s2 = 0; step();
    chk("R7", "S2 released", cpu_stop_n, 1);

    cur_tag = "R4"; sus_stat = 1; slp_sel = 1; stp_grant = 1; step();
    sus_stat = 0; stp_grant = 0;
    wake_evt = 1; step(); wake_evt = 0;
    repeat (3) step();
    chk("R4", "sleep wins, wake ignored", cpu_stop_n, 0);
    slp_s2 = 1; step(); slp_s2 = 0; step();
    chk("R4", "left through S2 path", cpu_stop_n, 1);

    cur_tag = "R8"; sus_stat = 1; slp_sel = 2; step(); sus_stat = 0;
    cpu_stp = 1; slp_s2 = 1; wake_evt = 1; step();
    cpu_stp = 0; slp_s2 = 0; wake_evt = 0;
    repeat (20) step();
    chk("R8", "deep stop held", cpu_stop_n, 0);
    chk("R8", "deep reset high", cpu_rst_n, 1);
    pwr_good = 0; step();
    chk("R1", "power-good low reset", cpu_rst_n, 0);
    step(); pwr_good = 1; step();
    chk("R8", "deep exit reset", cpu_rst_n, 1);
    chk("R8", "deep exit stop", cpu_stop_n, 1);

    cur_tag = "R10"; wr(2'd1, 8'd0);
    stp_grant = 1; step(); stp_grant = 0;
    wake_evt = 1; step(); wake_evt = 0;
    release_after(0, "R10");
    wr(2'd1, 8'd255);
    stp_grant = 1; step(); stp_grant = 0;
    wake_evt = 1; step(); wake_evt = 0;
    release_after(255, "R10");

    cur_tag = "R1"; stp_grant = 1; step(); stp_grant = 0;
    wake_evt = 1; step(); wake_evt = 0;
    pwr_good = 0; step();
    chk("R1", "override mid-count reset", cpu_rst_n, 0);
    chk("R1", "override mid-count stop", cpu_stop_n, 0);
    pwr_good = 1; step();
    chk("R2", "recovered", cpu_stop_n, 1);

    cur_tag = "R5";
    for (int i = 0; i < 10; i++) begin
      cpu_stp = i[0]; slp_s2 = ~i[0]; wake_evt = i[1]; step();
    end
    cpu_stp = 0; slp_s2 = 0; wake_evt = 0; step();
    chk("R5", "running without cause", cpu_stop_n, 1);

    proc_hot = 1; step();
    chk("R11", "no pulse after one edge", sci_req, 0);
    step();
    chk("R11", "sci pulse", sci_req, 1);
    chk("R11", "no smi in sci mode", smi_req, 0);
    step();
    chk("R11", "sci pulse ends", sci_req, 0);
    chk("R12", "status set", hot_status, 1);
    proc_hot = 0; repeat (3) step();
    wr(2'd2, 8'b01);
    chk("R12", "write without clear bit keeps status", hot_status, 1);
    proc_hot = 1; step(); step();
    chk("R11", "smi pulse", smi_req, 1);
    chk("R11", "no sci in smi mode", sci_req, 0);
    step(); proc_hot = 0; repeat (3) step();
    wr(2'd2, 8'b11);
    chk("R12", "status cleared", hot_status, 0);
    proc_hot = 1; step(); step();
    wr(2'd2, 8'b11);
    chk("R12", "set wins over clear", hot_status, 1);
    proc_hot = 0; repeat (4) step();
    finish_run();
  end
endmodule